// File: doc/BRIEF.md
# Serial Frame Transmitter with Half-Duplex Driver Enable

This block serializes bytes for one asynchronous serial channel. A byte arrives on a ready/valid interface and lands in a one-entry holding register. A frame engine then sends it as a low start bit, the selected number of data bits (least significant first), an optional parity bit and a stop period of one, one and a half or two bit times. All timing comes from a tick input that pulses sixteen times per bit. While no frame is being sent, the line rests high.

For half-duplex bus use, the block drives a transceiver enable. It raises the enable one tick before a start bit that follows an idle line. It keeps the enable high between frames that follow each other, and it keeps it high for one more bit time after the final stop period, so the last stop bit is fully driven onto the bus. Launching a new frame can be gated by an active-low clear-to-send input or by pause/resume indications that the companion receiver raises when it sees XOFF or XON. A frame that has already begun always runs to its end. Configuration inputs are static while the block is busy.

Top module: `uart_tx_rs485`

## Requirements
- R1: A frame is one start bit at 0, then the data bits least significant first, then stop bits at 1, and the line is 1 while idle. cfg_bits codes 0,1,2,3 select 5,6,7,8 data bits, and data bits above the selected width are ignored.
- R2: cfg_parity codes are 0 none, 1 odd, 2 even, 3 mark (always 1) and 4 space (always 0). Codes 5 to 7 act as none. Odd and even parity are computed over the selected data bits only.
- R3: cfg_stop codes 0, 1 and 2 give a stop period of 16, 24 and 32 ticks. Code 3 acts as 2.
- R4: Each start, data and parity bit lasts exactly 16 tick pulses, and the internal frame state changes only in cycles where tick is high.
- R5: in_ready is high exactly when the holding register is empty. A byte can be accepted while a frame is on the line. A waiting byte starts straight after the previous stop period, with no idle gap.
- R6: With cfg_rs485 high, drv_en rises one tick before a start bit that follows idle. It stays high across back-to-back frames and falls 16 ticks after the final stop period ends. With cfg_rs485 low, drv_en stays 0.
- R7: busy is high from the first tick of a frame (including the lead tick) until the driver-enable hold has expired, and it is low when idle.
- R8: With cfg_flow = 1, no frame starts while cts_n is high. A frame already started completes when cts_n rises.
- R9: With cfg_flow = 2, a pulse on xoff_seen pauses launching at the next frame boundary, and a pulse on xon_seen resumes it. xoff_seen wins when both pulse together. With cfg_flow = 0 or 3, cts_n and xoff_seen have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Oversampling tick, 16 per bit time |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Holding register can take a byte |
| cfg_bits | input | 2 | Data width code (5 to 8 bits) |
| cfg_parity | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop period code |
| cfg_flow | input | 2 | Flow control mode: 0 none, 1 clear-to-send, 2 XON/XOFF, 3 none |
| cfg_rs485 | input | 1 | Enable transceiver driver-enable control |
| cts_n | input | 1 | Clear to send, active low |
| xoff_seen | input | 1 | One-cycle pulse: XOFF (0x13) received |
| xon_seen | input | 1 | One-cycle pulse: XON (0x11) received |
| txd | output | 1 | Serial data line |
| drv_en | output | 1 | Transceiver driver enable |
| busy | output | 1 | Frame or driver hold in progress |

## Verification
The bench measures the busy and drv_en pulse widths in clock cycles against a tick budget computed from the format. A stop period that is cut short or stretched, a missing lead or hold tick, or a gap between queued frames shows up as an off-by-tick width. A receiver process in the bench samples each bit at its centre and checks the data against the byte masked to the chosen width and the parity bit against a computed value. This catches bit-order errors, parity taken over unused upper bits, and mark and space confusion. Directed cases hold off a waiting byte with clear-to-send, with XOFF, and with XOFF and XON in the same cycle, then drop clear-to-send mid-frame. A design that gates too early would truncate a frame, and one that ignores the gate would send while it should wait. Gating inputs are also toggled in a mode where they must have no effect.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } tx_state_e;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  localparam logic [1:0] FLOW_NONE = 2'd0;
  localparam logic [1:0] FLOW_HW   = 2'd1;
  localparam logic [1:0] FLOW_SW   = 2'd2;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              accept;

  assign accept = in_valid && !full_q;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (take)   full_d = 1'b0;
    if (accept) begin
      full_d = 1'b1;
      data_d = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign in_ready = !full_q;
  assign full     = full_q;
  assign data     = data_q;

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(data_q))); // R5
  AST_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q); // R5

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow import uart_tx_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_flow,
  input  logic       cts_n,
  input  logic       xoff_seen,
  input  logic       xon_seen,
  output logic       allow
);

  logic paused_q, paused_d;

  always_comb begin
    paused_d = paused_q;
    if (xoff_seen)     paused_d = 1'b1;
    else if (xon_seen) paused_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) paused_q <= 1'b0;
    else        paused_q <= paused_d;
  end

  always_comb begin
    case (cfg_flow)
      FLOW_HW: allow = !cts_n;
      FLOW_SW: allow = !paused_q;
      default: allow = 1'b1;
    endcase
  end

  AST_XOFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow == FLOW_SW && xoff_seen) |=> !allow); // R9

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame import uart_tx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        cfg_bits,
  input  logic [2:0]        cfg_parity,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_rs485,
  input  logic              go,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              txd,
  output logic              drv_en,
  output logic              busy
);

  localparam int CNT_W    = $clog2(2 * OVS);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVS + OVS / 2 - 1);
  localparam logic [CNT_W-1:0] TWO_LAST = CNT_W'(2 * OVS - 1);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic [IDX_W-1:0]  idx_last;
  logic [DATA_W-1:0] masked;
  logic [CNT_W-1:0]  stop_last;
  logic              par_on, par_calc, load;

  assign idx_last = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_bits);

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      masked[i] = hold_data[i] & (IDX_W'(i) <= idx_last);
  end

  assign par_on = (cfg_parity == PAR_ODD) || (cfg_parity == PAR_EVEN) ||
                  (cfg_parity == PAR_MARK) || (cfg_parity == PAR_SPACE);

  always_comb begin
    case (cfg_parity)
      PAR_ODD:  par_calc = ~(^masked);
      PAR_EVEN: par_calc = ^masked;
      PAR_MARK: par_calc = 1'b1;
      default:  par_calc = 1'b0;
    endcase
  end

  always_comb begin
    case (cfg_stop)
      2'd0:    stop_last = BIT_LAST;
      2'd1:    stop_last = MID_LAST;
      default: stop_last = TWO_LAST;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    par_d   = par_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          if (cfg_rs485) begin
            state_d = ST_LEAD;
            cnt_d   = '0;
          end else begin
            load = 1'b1;
          end
        end
      end
      ST_LEAD: load = 1'b1;
      ST_START: begin
        if (cnt_q == BIT_LAST) begin
          cnt_d   = '0;
          idx_d   = '0;
          state_d = ST_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        if (cnt_q == BIT_LAST) begin
          cnt_d = '0;
          sh_d  = sh_q >> 1;
          if (idx_q == idx_last) state_d = par_on ? ST_PAR : ST_STOP;
          else                   idx_d   = idx_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (cnt_q == BIT_LAST) begin
          cnt_d   = '0;
          state_d = ST_STOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (cnt_q == stop_last) begin
          cnt_d = '0;
          if (go)             load    = 1'b1;
          else if (cfg_rs485) state_d = ST_HOLD;
          else                state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (go)                     load    = 1'b1;
        else if (cnt_q == BIT_LAST) state_d = ST_IDLE;
        else                        cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (load) begin
      state_d = ST_START;
      cnt_d   = '0;
      sh_d    = hold_data;
      par_d   = par_calc;
    end
  end

  assign take = tick && load;

  // registers, enabled by the tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
    end else if (tick) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh_q[0];
      ST_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  assign busy   = (state_q != ST_IDLE);
  assign drv_en = cfg_rs485 && busy;

  AST_TICK_GATES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state_q)); // R4
  AST_LEAD_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rs485 && $fell(txd)) |-> $past(drv_en)); // R6
  AST_DE_COVERS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rs485 && !txd) |-> drv_en); // R6

endmodule

// File: rtl/uart_tx_rs485.sv
module uart_tx_rs485 import uart_tx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        cfg_bits,
  input  logic [2:0]        cfg_parity,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_flow,
  input  logic              cfg_rs485,
  input  logic              cts_n,
  input  logic              xoff_seen,
  input  logic              xon_seen,
  output logic              txd,
  output logic              drv_en,
  output logic              busy
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              hold_full, take, allow;
  logic [DATA_W-1:0] hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  uart_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  uart_tx_flow i_flow (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_flow  (cfg_flow),
    .cts_n     (cts_n),
    .xoff_seen (xoff_seen),
    .xon_seen  (xon_seen),
    .allow     (allow)
  );

  uart_tx_frame #(.DATA_W(DATA_W), .OVS(OVS)) i_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .cfg_bits   (cfg_bits),
    .cfg_parity (cfg_parity),
    .cfg_stop   (cfg_stop),
    .cfg_rs485  (cfg_rs485),
    .go         (hold_full && allow),
    .hold_data  (hold_data),
    .take       (take),
    .txd        (txd),
    .drv_en     (drv_en),
    .busy       (busy)
  );

  AST_LAUNCH_GATED: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy) |-> $past(allow)); // R8
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (txd && !drv_en)); // R1

endmodule

// File: tb/test_uart_tx_rs485.sv
module test_uart_tx_rs485;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n, tick;
  logic [7:0] in_data;
  logic       in_valid, in_ready;
  logic [1:0] cfg_bits, cfg_stop, cfg_flow;
  logic [2:0] cfg_parity;
  logic       cfg_rs485, cts_n, xoff_seen, xon_seen;
  logic       txd, drv_en, busy;

  int checks = 0;
  int fails  = 0;
  int tdiv   = 0;
  logic [7:0] exp_q[$];

  uart_tx_rs485 i_uart_tx_rs485 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_bits(cfg_bits),
    .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .cfg_flow(cfg_flow),
    .cfg_rs485(cfg_rs485), .cts_n(cts_n), .xoff_seen(xoff_seen),
    .xon_seen(xon_seen), .txd(txd), .drv_en(drv_en), .busy(busy)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      tick = (tdiv == 0);
    end
  end

  function automatic int nb(input logic [1:0] c);
    return 5 + int'(c);
  endfunction

  function automatic bit has_par(input logic [2:0] p);
    return (p >= 3'd1 && p <= 3'd4);
  endfunction

  function automatic logic [7:0] mask_d(input logic [7:0] d, input logic [1:0] c);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < nb(c); i++) m[i] = d[i];
    return m;
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] c, input logic [2:0] p);
    logic [7:0] m;
    m = mask_d(d, c);
    case (p)
      3'd1:    return ~(^m);
      3'd2:    return ^m;
      3'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int stop_t(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
  endfunction

  function automatic int frame_t(input logic [1:0] c, input logic [2:0] p, input logic [1:0] s);
    return 16 * (1 + nb(c) + (has_par(p) ? 1 : 0)) + stop_t(s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    finish_up();
  end

  // bench receiver: samples each bit at its centre
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && txd === 1'b0) begin
        logic [7:0] got, e;
        logic g0, gp, gs;
        got = '0;
        gp  = 1'b0;
        repeat (8 * TICK_DIV) @(negedge clk);
        g0 = txd;
        for (int i = 0; i < nb(cfg_bits); i++) begin
          repeat (16 * TICK_DIV) @(negedge clk);
          got[i] = txd;
        end
        if (has_par(cfg_parity)) begin
          repeat (16 * TICK_DIV) @(negedge clk);
          gp = txd;
        end
        repeat (16 * TICK_DIV) @(negedge clk);
        gs = txd;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 frame with no byte queued", int'(got), -1);
        end else begin
          e = exp_q.pop_front();
          chk(got == mask_d(e, cfg_bits) && !g0 && gs, "R1 frame data/start/stop",
              int'(got), int'(mask_d(e, cfg_bits)));
          if (has_par(cfg_parity))
            chk(gp == exp_par(e, cfg_bits, cfg_parity), "R2 parity bit",
                int'(gp), int'(exp_par(e, cfg_bits, cfg_parity)));
        end
      end
    end
  end

  task automatic send(input logic [7:0] d);
    logic rdy;
    @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    forever begin
      rdy = in_ready;
      @(negedge clk);
      if (rdy) break;
    end
    in_valid = 1'b0;
  endtask

  // measure one busy pulse, in ticks
  task automatic measure(input int exp_ticks, input bit rs, input int cts_drop);
    int w, bc, dc, fz;
    w = 0; bc = 0; dc = 0; fz = -1;
    while (!busy && w < 4000) begin
      @(negedge clk);
      w++;
    end
    chk(busy, "R7 busy never rose", int'(busy), 1);
    while (busy && bc < 20000) begin
      if (drv_en) dc++;
      if (!txd && fz < 0) fz = bc;
      if (bc == cts_drop) cts_n = 1'b1;
      bc++;
      @(negedge clk);
    end
    chk(bc == exp_ticks * TICK_DIV, "R7 R3 busy width (cycles)", bc, exp_ticks * TICK_DIV);
    chk(dc == (rs ? exp_ticks * TICK_DIV : 0), "R6 drv_en width (cycles)", dc,
        rs ? exp_ticks * TICK_DIV : 0);
    chk(fz == (rs ? TICK_DIV : 0), "R6 R4 start offset after busy", fz, rs ? TICK_DIV : 0);
  endtask

  task automatic set_cfg(input logic [1:0] b, input logic [2:0] p, input logic [1:0] s,
                         input logic [1:0] f, input logic rs);
    @(negedge clk);
    cfg_bits = b; cfg_parity = p; cfg_stop = s; cfg_flow = f; cfg_rs485 = rs;
  endtask

  task automatic pulse(input logic xf, input logic xn);
    @(negedge clk);
    xoff_seen = xf;
    xon_seen  = xn;
    @(negedge clk);
    xoff_seen = 1'b0;
    xon_seen  = 1'b0;
  endtask

  task automatic expect_quiet(input string req);
    repeat (64 * TICK_DIV) @(negedge clk);
    chk(!busy && txd, req, int'(busy), 0);
  endtask

  task automatic second_byte(input logic [7:0] d);
    send(d);
    chk(!in_ready, "R5 in_ready low while holding", int'(in_ready), 0);
  endtask

  initial begin
    int ft;
    in_data = '0; in_valid = 1'b0; cts_n = 1'b0; xoff_seen = 1'b0; xon_seen = 1'b0;
    cfg_bits = 2'd3; cfg_parity = 3'd0; cfg_stop = 2'd0; cfg_flow = 2'd0; cfg_rs485 = 1'b0;
    void'($urandom(32'd7331));
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk(txd == 1'b1, "R1 idle line after reset", int'(txd), 1);
    chk(busy == 1'b0, "R7 busy after reset", int'(busy), 0);
    chk(drv_en == 1'b0, "R6 drv_en after reset", int'(drv_en), 0);
    chk(in_ready == 1'b1, "R5 in_ready after reset", int'(in_ready), 1);

    // R5: back-to-back, no driver control, 8E1
    set_cfg(2'd3, 3'd2, 2'd0, 2'd0, 1'b0);
    ft = frame_t(2'd3, 3'd2, 2'd0);
    exp_q.push_back(8'hA5);
    exp_q.push_back(8'h3C);
    send(8'hA5);
    fork
      second_byte(8'h3C);
      measure(2 * ft, 1'b0, -1);
    join

    // R6: back-to-back with driver control, 7 bits, mark, 1.5 stop
    set_cfg(2'd2, 3'd3, 2'd1, 2'd0, 1'b1);
    ft = frame_t(2'd2, 3'd3, 2'd1);
    exp_q.push_back(8'hF0);
    exp_q.push_back(8'h81);
    send(8'hF0);
    fork
      second_byte(8'h81);
      measure(1 + 2 * ft + 16, 1'b1, -1);
    join

    // R8: clear-to-send holds a waiting byte, drop mid-frame completes it
    set_cfg(2'd3, 3'd1, 2'd2, 2'd1, 1'b0);
    ft = frame_t(2'd3, 3'd1, 2'd2);
    cts_n = 1'b1;
    exp_q.push_back(8'h5A);
    send(8'h5A);
    expect_quiet("R8 no start while cts_n high");
    cts_n = 1'b0;
    measure(ft, 1'b0, 40);
    cts_n = 1'b0;

    // R9: XOFF pauses, XON resumes
    set_cfg(2'd0, 3'd4, 2'd0, 2'd2, 1'b1);
    ft = frame_t(2'd0, 3'd4, 2'd0);
    pulse(1'b1, 1'b0);
    exp_q.push_back(8'hFF);
    send(8'hFF);
    expect_quiet("R9 no start after XOFF");
    pulse(1'b0, 1'b1);
    measure(1 + ft + 16, 1'b1, -1);

    // R9: XOFF wins over simultaneous XON
    pulse(1'b1, 1'b1);
    exp_q.push_back(8'h13);
    send(8'h13);
    expect_quiet("R9 XOFF wins over XON");
    pulse(1'b0, 1'b1);
    measure(1 + ft + 16, 1'b1, -1);

    // R9: gating inputs ignored with flow mode 0
    set_cfg(2'd1, 3'd5, 2'd3, 2'd0, 1'b0);
    cts_n = 1'b1;
    pulse(1'b1, 1'b0);
    exp_q.push_back(8'hC6);
    send(8'hC6);
    measure(frame_t(2'd1, 3'd5, 2'd3), 1'b0, -1);
    cts_n = 1'b0;
    pulse(1'b0, 1'b1);

    // random formats and data
    for (int k = 0; k < 30; k++) begin
      logic [1:0] b, s;
      logic [2:0] p;
      logic rs;
      logic [7:0] d;
      b  = 2'($urandom % 4);
      p  = 3'($urandom % 8);
      s  = 2'($urandom % 4);
      rs = 1'($urandom % 2);
      d  = 8'($urandom);
      set_cfg(b, p, s, 2'($urandom % 2 == 0 ? 0 : 3), rs);
      exp_q.push_back(d);
      send(d);
      measure(frame_t(b, p, s) + (rs ? 17 : 0), rs, -1);
    end

    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all bytes framed", exp_q.size(), 0);
    finish_up();
  end

endmodule